// File: doc/BRIEF.md
# Ping-Pong Serial Line Buffer

This block stores a line of serial bits in one of two equal banks while the other bank plays back the previous line. Writing uses the rising edge of the write clock, gated by an active-low input enable. Reading uses the falling edge of the read clock, gated by an active-low output enable. Read data leaves through an output register, so output timing does not depend on the memory access path. An external toggle swaps the roles of the two banks. The toggle records how many bits were written, so the read side stops at the end of the line.

Two active-low flags report the line state. `full_n` drops when the last bank entry is written and then blocks further writes. `wr_req_n` drops once the whole stored line has been played back and then blocks further reads. A toggle releases both flags. Each side has its own active-low rewind input: the write side can restart a line, and the read side can replay one. A chip select gates every input except reset. After the final bit has gone out, the data output holds a level chosen by a strap input. The toggle, the rewinds, the write bank and the reset reach each clock domain through two-flop synchronizers, so the two clocks may be unrelated.

Top module: `pingpong_line_buf`

## Requirements
- R1: Reset drives `dout` low and both `full_n` and `wr_req_n` high, whatever the level of `cs_n`.
- R2: A bit on `din` is stored on a rising `wr_clk` edge only when `cs_n` and `ice_n` are both low and `full_n` is high. Stored bits are appended in arrival order.
- R3: On a falling `rd_clk` edge with `cs_n` and `oce_n` both low, `dout` presents the next stored bit of the read bank, in the order the bits were written.
- R4: A rising edge on `toggle` swaps the banks. The line written before the toggle becomes readable from its first bit, and both `full_n` and `wr_req_n` return high.
- R5: `full_n` goes low on the write edge that stores entry number DEPTH. Later writes have no effect until a toggle or a write rewind.
- R6: `wr_req_n` goes low on the rising `rd_clk` edge that follows output of the last stored bit, and stays high until then. While it is low, reads have no effect. A line shorter than DEPTH is played back only up to its written length.
- R7: A low on `wr_rewind_n` restarts the write address at zero, so the next bits overwrite the line from its start.
- R8: A low on `rd_rewind_n` puts the first bit of the read bank on `dout`, sets `wr_req_n` high, and lets the next reads continue from the second bit.
- R9: While `cs_n` is high, `toggle`, both rewinds, `ice_n` and `oce_n` have no effect.
- R10: Before the first toggle after reset, no read takes place and `dout` stays low.
- R11: While `wr_req_n` is low, `dout` follows the `idle_lvl` strap.
- R12: A toggle with no bits written gives an empty read line: `wr_req_n` goes low right after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, rising edge active |
| rd_clk | input | 1 | Read clock, data advances on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| ice_n | input | 1 | Active-low write enable |
| din | input | 1 | Serial write data |
| oce_n | input | 1 | Active-low read enable |
| toggle | input | 1 | Bank swap, acts on its rising edge |
| wr_rewind_n | input | 1 | Active-low write address rewind |
| rd_rewind_n | input | 1 | Active-low read address rewind |
| idle_lvl | input | 1 | Output level once the line is exhausted |
| dout | output | 1 | Serial read data |
| full_n | output | 1 | Low when the write bank is full |
| wr_req_n | output | 1 | Low when the read line is exhausted |

## Verification
The bench builds the block with DEPTH = 40 and WORD_W = 8. With these values a full line takes only forty writes, and each bank spans five storage words, so full-line overflow and word-boundary crossings are both exercised often. Both clocks are tied to one source, which makes the synchronizer delays fixed. Because of this, playback order, exhaustion, replay and the idle level can all be checked at exact sample points, both while reading and writing happen together and while only one side is active.

// File: rtl/plb_pkg.sv
package plb_pkg;
  // Number of storage words needed to hold one bank of depth bits.
  function automatic int words_for(input int depth, input int width);
    return (depth + width - 1) / width;
  endfunction
endpackage

// File: rtl/plb_sync.sv
module plb_sync #(
  parameter int STAGES    = 2,
  parameter bit RST_VAL   = 1'b0,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/plb_bank_store.sv
module plb_bank_store #(
  parameter int DEPTH  = 5120,
  parameter int WORD_W = 32,
  parameter int AW     = $clog2(DEPTH + 1)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int WORDS = plb_pkg::words_for(DEPTH, WORD_W);
  localparam int OFFW  = $clog2(WORD_W);
  localparam int MIW   = $clog2(2 * WORDS);

  logic [WORD_W-1:0] mem [2*WORDS];
  logic [MIW-1:0]    widx;
  logic [MIW-1:0]    ridx;

  assign widx = (wbank ? MIW'(WORDS) : MIW'(0)) + MIW'(waddr >> OFFW);
  assign ridx = (rbank ? MIW'(WORDS) : MIW'(0)) + MIW'(raddr >> OFFW);

  always_ff @(posedge wr_clk) begin
    if (we) mem[widx][waddr[OFFW-1:0]] <= wbit;
  end

  assign rbit = mem[ridx][raddr[OFFW-1:0]];
endmodule

// File: rtl/plb_wr_ctl.sv
module plb_wr_ctl #(
  parameter int DEPTH = 5120,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ice_n,
  input  logic          toggle,
  input  logic          rew_n,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic          bank,
  output logic [AW-1:0] len,
  output logic          full_n
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic tgl_s, tgl_d, rew_s;
  logic tgl_edge, rew_act;
  logic [AW-1:0] addr_q, addr_n, len_q, len_n;
  logic bank_q, bank_n, full_q, full_n_nx;

  plb_sync #(.STAGES(2), .RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d(toggle), .q(tgl_s));
  plb_sync #(.STAGES(2), .RST_VAL(1'b1), .FALL_EDGE(1'b0)) u_rew_sync (
    .clk(clk), .rst_n(rst_n), .d(rew_n), .q(rew_s));

  assign tgl_edge = tgl_s & ~tgl_d & ~cs_n;
  assign rew_act  = ~rew_s & ~cs_n;
  assign we       = ~cs_n & ~ice_n & full_q & ~tgl_edge & ~rew_act;

  always_comb begin
    addr_n    = addr_q;
    len_n     = len_q;
    bank_n    = bank_q;
    full_n_nx = full_q;
    if (tgl_edge) begin
      bank_n    = ~bank_q;
      len_n     = addr_q;
      addr_n    = '0;
      full_n_nx = 1'b1;
    end else if (rew_act) begin
      addr_n    = '0;
      full_n_nx = 1'b1;
    end else if (we) begin
      addr_n = addr_q + 1'b1;
      if (addr_q == LAST) full_n_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_d  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      bank_q <= 1'b0;
      full_q <= 1'b1;
    end else begin
      tgl_d  <= tgl_s;
      addr_q <= addr_n;
      len_q  <= len_n;
      bank_q <= bank_n;
      full_q <= full_n_nx;
    end
  end

  assign addr   = addr_q;
  assign bank   = bank_q;
  assign len    = len_q;
  assign full_n = full_q;
endmodule

// File: rtl/plb_rd_ctl.sv
module plb_rd_ctl #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oce_n,
  input  logic          rew_n,
  input  logic          wbank,
  input  logic [AW-1:0] wlen,
  input  logic          rbit,
  input  logic          idle_lvl,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] len,
  output logic          rbank,
  output logic          dout,
  output logic          req_n
);
  logic bk_s, bk_d, rew_s;
  logic flip, rew_act, rd_go;
  logic valid_q, valid_n, dq, dq_n, req_q;
  logic [AW-1:0] addr_q, addr_n, len_q, len_n;

  // The write bank bit is the crossing signal: it changes once per toggle,
  // together with the captured length, which is stable by the time it lands.
  plb_sync #(.STAGES(2), .RST_VAL(1'b0), .FALL_EDGE(1'b1)) u_bank_sync (
    .clk(clk), .rst_n(rst_n), .d(wbank), .q(bk_s));
  plb_sync #(.STAGES(2), .RST_VAL(1'b1), .FALL_EDGE(1'b1)) u_rew_sync (
    .clk(clk), .rst_n(rst_n), .d(rew_n), .q(rew_s));

  assign flip    = bk_s ^ bk_d;
  assign rew_act = ~rew_s & ~cs_n & valid_q;
  assign rd_go   = ~cs_n & ~oce_n & req_q & valid_q & (addr_q < len_q) & ~flip & ~rew_act;

  always_comb begin
    addr_n  = addr_q;
    len_n   = len_q;
    valid_n = valid_q;
    dq_n    = dq;
    if (flip) begin
      len_n   = wlen;
      addr_n  = '0;
      valid_n = 1'b1;
      dq_n    = idle_lvl;
    end else if (rew_act) begin
      if (len_q != '0) begin
        addr_n = AW'(1);
        dq_n   = rbit;
      end else begin
        addr_n = '0;
      end
    end else if (rd_go) begin
      dq_n   = rbit;
      addr_n = addr_q + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_d    <= 1'b0;
      valid_q <= 1'b0;
      len_q   <= '0;
      addr_q  <= '0;
      dq      <= 1'b0;
    end else begin
      bk_d    <= bk_s;
      valid_q <= valid_n;
      len_q   <= len_n;
      addr_q  <= addr_n;
      dq      <= dq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              req_q <= 1'b1;
    else if (flip || rew_act)                req_q <= 1'b1;
    else if (valid_q && (addr_q == len_q))   req_q <= 1'b0;
  end

  assign mem_addr = rew_act ? '0 : addr_q;
  assign addr     = addr_q;
  assign len      = len_q;
  assign rbank    = ~bk_d;
  assign req_n    = req_q;
  assign dout     = (valid_q & ~req_q) ? idle_lvl : dq;
endmodule

// File: rtl/pingpong_line_buf.sv
module pingpong_line_buf #(
  parameter int DEPTH  = 5120,
  parameter int WORD_W = 32
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ice_n,
  input  logic din,
  input  logic oce_n,
  input  logic toggle,
  input  logic wr_rewind_n,
  input  logic rd_rewind_n,
  input  logic idle_lvl,
  output logic dout,
  output logic full_n,
  output logic wr_req_n
);
  localparam int AW = $clog2(DEPTH + 1);

  logic          wr_rst_n, rd_rst_n;
  logic          wr_we, wr_bank, rd_bank, rd_bit;
  logic [AW-1:0] wr_addr, wr_len, rd_mem_addr, rd_addr, rd_len;

  plb_sync #(.STAGES(2), .RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_wr_rst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));
  plb_sync #(.STAGES(2), .RST_VAL(1'b0), .FALL_EDGE(1'b1)) u_rd_rst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));

  plb_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .cs_n(cs_n), .ice_n(ice_n),
    .toggle(toggle), .rew_n(wr_rewind_n), .we(wr_we), .addr(wr_addr),
    .bank(wr_bank), .len(wr_len), .full_n(full_n));

  plb_bank_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_store (
    .wr_clk(wr_clk), .we(wr_we), .wbank(wr_bank), .waddr(wr_addr), .wbit(din),
    .rbank(rd_bank), .raddr(rd_mem_addr), .rbit(rd_bit));

  plb_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .cs_n(cs_n), .oce_n(oce_n),
    .rew_n(rd_rewind_n), .wbank(wr_bank), .wlen(wr_len), .rbit(rd_bit),
    .idle_lvl(idle_lvl), .mem_addr(rd_mem_addr), .addr(rd_addr), .len(rd_len),
    .rbank(rd_bank), .dout(dout), .req_n(wr_req_n));
endmodule

// File: rtl/pingpong_line_buf_chk.sv
module pingpong_line_buf_chk #(
  parameter int DEPTH = 5120
) (
  input logic                         wr_clk,
  input logic                         rd_clk,
  input logic                         rst_n,
  input logic                         full_n,
  input logic                         wr_req_n,
  input logic [$clog2(DEPTH+1)-1:0]   wr_addr,
  input logic [$clog2(DEPTH+1)-1:0]   rd_addr,
  input logic [$clog2(DEPTH+1)-1:0]   rd_len
);
  localparam int AW = $clog2(DEPTH + 1);

  // R5: a full bank does not advance; only a rewind or toggle moves the address
  assert_full_holds_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && $past(!full_n)) |-> (wr_addr == $past(wr_addr) || wr_addr == '0));

  // R5: full is flagged exactly when the last entry has been written
  assert_full_at_depth_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $fell(full_n) |-> (wr_addr == AW'(DEPTH)));

  // R2: the write address never runs past the bank
  assert_wr_in_bank_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_addr <= AW'(DEPTH));

  // R3: playback never passes the recorded line length
  assert_rd_in_line_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_addr <= rd_len);

  // R6: exhaustion is flagged only at the end of the stored line
  assert_req_at_end_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $fell(wr_req_n) |-> (rd_addr == rd_len));

  // R6: while exhausted, reads do not move the read address
  assert_read_blocked_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!wr_req_n && $past(!wr_req_n)) |-> (rd_addr == $past(rd_addr) || rd_addr <= AW'(1)));
endmodule

bind pingpong_line_buf pingpong_line_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .full_n(full_n),
  .wr_req_n(wr_req_n), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_len(rd_len));

// File: tb/pingpong_line_buf_tb.sv
module pingpong_line_buf_tb;
  localparam int DEPTH  = 40;
  localparam int WORD_W = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, ice_n, din, oce_n, toggle, wr_rewind_n, rd_rewind_n, idle_lvl;
  logic dout, full_n, wr_req_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic wline [0:63];
  logic rline [0:63];
  int   rlen;

  always #10 clk = ~clk;

  pingpong_line_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ice_n(ice_n),
    .din(din), .oce_n(oce_n), .toggle(toggle), .wr_rewind_n(wr_rewind_n),
    .rd_rewind_n(rd_rewind_n), .idle_lvl(idle_lvl), .dout(dout),
    .full_n(full_n), .wr_req_n(wr_req_n));

  function automatic logic exp_bit(input int i);
    return rline[i];
  endfunction

  function automatic int pick_len();
    return 1 + int'($urandom % DEPTH);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++) wline[i] = 1'($urandom);
  endtask

  task automatic write_bits(input int start, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      ice_n = 1'b0;
      din   = wline[start + i];
    end
    @(posedge clk); #5;
    ice_n = 1'b1;
  endtask

  task automatic do_toggle();
    @(posedge clk); #5 toggle = 1'b1;
    repeat (3) @(posedge clk);
    #5 toggle = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic adopt(input int n);
    for (int i = 0; i < n; i++) rline[i] = wline[i];
    rlen = n;
  endtask

  task automatic read_check(input int start, input int n, input string req);
    @(posedge clk); #5 oce_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #3;
      chk(req, dout, exp_bit(start + i));
      if (i == n - 1) chk("R6 not early", wr_req_n, 1'b1);
    end
    oce_n = 1'b1;
  endtask

  task automatic exhausted_check(input string req);
    repeat (2) @(posedge clk); #3;
    chk(req, wr_req_n, 1'b0);
    chk("R11 idle level", dout, idle_lvl);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cs_n = 1'b1; ice_n = 1'b1; din = 1'b0; oce_n = 1'b1;
    toggle = 1'b0; wr_rewind_n = 1'b1; rd_rewind_n = 1'b1; idle_lvl = 1'b1;
    rlen = 0;
    repeat (5) @(posedge clk); #3;
    chk("R1 dout in reset", dout, 1'b0);
    chk("R1 full in reset", full_n, 1'b1);
    chk("R1 req in reset", wr_req_n, 1'b1);
    #2 rst_n = 1'b1;
    repeat (6) @(posedge clk); #5;
    cs_n = 1'b0;

    // R10: first line period, reads do nothing
    fill_random(13);
    write_bits(0, 13);
    @(posedge clk); #5 oce_n = 1'b0;
    repeat (4) @(negedge clk);
    #3;
    chk("R10 no read before toggle", dout, 1'b0);
    chk("R10 req still high", wr_req_n, 1'b1);
    oce_n = 1'b1;

    // R4 / R3 / R2: swap and play back a short line
    do_toggle();
    adopt(13);
    chk("R4 full after toggle", full_n, 1'b1);
    chk("R4 req after toggle", wr_req_n, 1'b1);
    read_check(0, 13, "R3 playback order");
    exhausted_check("R6 short line end");

    // R6: further reads are ignored
    @(posedge clk); #5 oce_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk("R6 reads blocked req", wr_req_n, 1'b0);
    chk("R6 reads blocked dout", dout, 1'b1);
    oce_n = 1'b1;
    // R11: strap picks the idle level
    idle_lvl = 1'b0; #1;
    chk("R11 idle low", dout, 1'b0);
    idle_lvl = 1'b1; #1;
    chk("R11 idle high", dout, 1'b1);

    // R5: full line, extra writes dropped
    fill_random(44);
    write_bits(0, DEPTH - 1);
    chk("R5 not full early", full_n, 1'b1);
    write_bits(DEPTH - 1, 1);
    chk("R5 full at depth", full_n, 1'b0);
    write_bits(DEPTH, 4);
    chk("R5 stays full", full_n, 1'b0);
    do_toggle();
    adopt(DEPTH);
    chk("R4 full cleared", full_n, 1'b1);
    read_check(0, DEPTH, "R5 full line data");
    exhausted_check("R5 length is depth");

    // R7: write rewind
    fill_random(10);
    write_bits(0, 10);
    @(posedge clk); #5 wr_rewind_n = 1'b0;
    repeat (4) @(posedge clk);
    #5 wr_rewind_n = 1'b1;
    repeat (4) @(posedge clk);
    fill_random(7);
    write_bits(0, 7);
    do_toggle();
    adopt(7);
    read_check(0, 4, "R7 rewritten line");

    // R8: read rewind and replay
    @(posedge clk); #5 rd_rewind_n = 1'b0;
    repeat (4) @(posedge clk);
    #5 rd_rewind_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #3;
    chk("R8 first bit shown", dout, exp_bit(0));
    chk("R8 req high", wr_req_n, 1'b1);
    read_check(1, 6, "R8 replay order");
    exhausted_check("R8 replay end");

    // R9: deselected inputs are ignored
    @(posedge clk); #5 cs_n = 1'b1;
    do_toggle();
    fill_random(5);
    write_bits(0, 5);
    @(posedge clk); #5 rd_rewind_n = 1'b0; wr_rewind_n = 1'b0;
    repeat (4) @(posedge clk);
    #5 rd_rewind_n = 1'b1; wr_rewind_n = 1'b1;
    repeat (6) @(posedge clk);
    #3;
    chk("R9 req unchanged", wr_req_n, 1'b0);
    chk("R9 dout unchanged", dout, 1'b1);
    #2 cs_n = 1'b0;
    fill_random(6);
    write_bits(0, 6);
    do_toggle();
    adopt(6);
    read_check(0, 6, "R9 line length intact");
    exhausted_check("R9 length six");

    // R12: empty line
    do_toggle();
    #3;
    chk("R12 empty line req", wr_req_n, 1'b0);
    chk("R12 empty line idle", dout, idle_lvl);

    // Random rounds with concurrent write and read
    begin
      int nl;
      nl = pick_len();
      fill_random(nl);
      write_bits(0, nl);
      do_toggle();
      adopt(nl);
      for (int k = 0; k < 5; k++) begin
        int wl;
        wl = pick_len();
        idle_lvl = 1'($urandom);
        fill_random(wl);
        fork
          read_check(0, rlen, "R3 random playback");
          write_bits(0, wl);
        join
        exhausted_check("R6 random end");
        do_toggle();
        adopt(wl);
      end
    end

    finish_run();
  end
endmodule